// File: doc/BRIEF.md
# Lockable Base-Address Window Decoder

This block owns one 64-bit configuration register that places a 16 KB, naturally aligned memory-mapped window somewhere inside a 36-bit (64 GB) physical address space, and gives that window an enable bit. Software reaches the register through a small configuration port as two 32-bit halves with byte enables.

For every memory request address the decoder answers in the same cycle. It reports whether the window claims the request and whether the claimed access is permitted. It also reports the 14-bit offset of the request inside the window.

Two independent security lock inputs change its behaviour. The first is a trusted-execution mode and the second is a management-engine lock. When either one is high, the base and enable fields cannot be changed. A claimed access is then only permitted at a short list of fixed offset ranges. Everything else inside the window is refused.

Top module: `cfgwin_decoder`

## Requirements
- R1: `win_claim` is high exactly when `req_valid` is high, the enable bit is 1, `req_addr[63:36]` is all zero and `req_addr[35:14]` equals the stored base. Clearing the enable bit drops the claim for every address.
- R2: `win_offset` equals `req_addr[13:0]` while `win_claim` is high and is zero otherwise.
- R3: After reset the register reads all zeros, the window is disabled, and no address is claimed.
- R4: The low half of the register sits at configuration offset 0x48 and holds the enable in bit 0 and base address bits 31:14 in bits 31:14. The high half sits at offset 0x4C and holds base bits 35:32 in bits 3:0. Read data appears on `cfg_rdata` on the clock edge that samples `cfg_rd_en`. A read at any other offset returns zero.
- R5: Low-half bits 13:1 and high-half bits 31:4 always read 0, and writing ones to them changes nothing.
- R6: A write updates only the bytes whose `cfg_be` bit is set. `cfg_be[k]` covers `cfg_wdata[8k+7:8k]`.
- R7: While either lock input is high, writes to the base and enable fields have no effect. Reads still return the stored values, and claiming continues with them.
- R8: With both locks low, `win_permit` equals `win_claim`.
- R9: With a lock high, a claimed access is permitted only at window offsets 0x02B8 to 0x02BF, 0x06B8 to 0x06BF, 0x0CD0 to 0x0CFF and 0x3000 to 0x3FFF, with both ends of each range included.
- R10: Each lock input alone is enough to apply the restrictions of R7 and R9.
- R11: `win_permit` is never high while `win_claim` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration byte offset (0x48 low half, 0x4C high half) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Registered read data |
| lock_trusted | input | 1 | Trusted-execution mode lock |
| lock_mgmt | input | 1 | Management-engine security lock |
| req_valid | input | 1 | A memory request address is presented |
| req_addr | input | 64 | Memory request byte address |
| win_claim | output | 1 | The window claims the request |
| win_permit | output | 1 | The claimed request may proceed |
| win_offset | output | 14 | Offset of the request inside the window |

## Verification
The stored base and enable are the only internal state, and both are visible in two ways. A read of the register shows them one cycle after the read strobe. Any request shows them in the same cycle through `win_claim`.

A write that slips past a lock, or a byte lane that gets merged wrongly, therefore shows up on the next read or the next request. The read-back pattern tells which byte went wrong. The whitelist is pure combinational logic on the offset, so an error in one range limit shows only when a request lands on that exact boundary byte. For that reason the first and last byte of every range, and the byte just outside each one, are driven directly.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int REQ_AW   = 64;
  localparam int PHYS_AW  = 36;
  localparam int WIN_LOG2 = 14;
  localparam int BASE_W   = PHYS_AW - WIN_LOG2;
  localparam int CFG_DW   = 32;
  localparam int CFG_AW   = 8;
  localparam logic [CFG_AW-1:0] OFS_LO = 8'h48;
  localparam logic [CFG_AW-1:0] OFS_HI = 8'h4C;

  // Offset spans that stay reachable while a lock is active.
  localparam int N_SPANS = 4;
  typedef struct packed {
    logic [WIN_LOG2-1:0] first;
    logic [WIN_LOG2-1:0] last;
  } span_t;

  localparam span_t OPEN_SPANS [N_SPANS] = '{
    '{first: 14'h02B8, last: 14'h02BF},
    '{first: 14'h06B8, last: 14'h06BF},
    '{first: 14'h0CD0, last: 14'h0CFF},
    '{first: 14'h3000, last: 14'h3FFF}
  };

  function automatic logic [BASE_W-1:0] page_of(input logic [REQ_AW-1:0] a);
    return a[PHYS_AW-1:WIN_LOG2];
  endfunction

  function automatic logic beyond_phys(input logic [REQ_AW-1:0] a);
    return |a[REQ_AW-1:PHYS_AW];
  endfunction

  function automatic logic [WIN_LOG2-1:0] offset_of(input logic [REQ_AW-1:0] a);
    return a[WIN_LOG2-1:0];
  endfunction

  function automatic logic inside_span(input logic [WIN_LOG2-1:0] o, input span_t s);
    return (o >= s.first) && (o <= s.last);
  endfunction

endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
#(
  parameter int BASE_BITS = BASE_W,
  parameter int LOW_BITS  = WIN_LOG2,
  parameter int DW        = CFG_DW,
  parameter int AW        = CFG_AW,
  parameter logic [AW-1:0] LO_ADDR = OFS_LO,
  parameter logic [AW-1:0] HI_ADDR = OFS_HI
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [DW/8-1:0]      be,
  input  logic                 lock_any,
  output logic [DW-1:0]        rdata,
  output logic [BASE_BITS-1:0] base,
  output logic                 enable
);
  localparam int REG_W = 2 * DW;
  localparam int NBYTE = DW / 8;
  localparam int TOP_USED = BASE_BITS + LOW_BITS - DW;
  localparam logic [REG_W-1:0] EN_MASK   = {{(REG_W-1){1'b0}}, 1'b1};
  localparam logic [REG_W-1:0] BASE_MASK =
    {{(REG_W-BASE_BITS){1'b0}}, {BASE_BITS{1'b1}}} << LOW_BITS;
  localparam logic [REG_W-1:0] WMASK = EN_MASK | BASE_MASK;

  logic [REG_W-1:0] img_q;
  logic [DW-1:0]    lane_bits;
  logic [REG_W-1:0] lane_mask;
  logic             sel_lo, sel_hi, wr_hit, write_go, wr_blocked;
  logic             rd_lo_q, rd_hi_q;

  assign sel_lo = (addr == LO_ADDR);
  assign sel_hi = (addr == HI_ADDR);
  assign wr_hit = wr_en && (sel_lo || sel_hi);
  assign write_go   = wr_hit && !lock_any;
  assign wr_blocked = wr_hit && lock_any;

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    assign lane_bits[b*8 +: 8] = {8{be[b]}};
  end

  always_comb begin
    lane_mask = '0;
    if (sel_lo) lane_mask = {{DW{1'b0}}, lane_bits};
    else if (sel_hi) lane_mask = {lane_bits, {DW{1'b0}}};
    lane_mask = lane_mask & WMASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      img_q <= '0;
    end else if (write_go) begin
      img_q <= (img_q & ~lane_mask) | ({wdata, wdata} & lane_mask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      rd_lo_q <= 1'b0;
      rd_hi_q <= 1'b0;
    end else begin
      rd_lo_q <= rd_en && sel_lo;
      rd_hi_q <= rd_en && sel_hi;
      if (rd_en) begin
        if (sel_lo)      rdata <= img_q[DW-1:0];
        else if (sel_hi) rdata <= img_q[REG_W-1:DW];
        else             rdata <= '0;
      end
    end
  end

  assign base   = img_q[LOW_BITS +: BASE_BITS];
  assign enable = img_q[0];

  // R7: a write presented under lock leaves base and enable untouched
  assert_locked_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> ($stable(base) && $stable(enable)));

  // R5: reserved bits of the low half read as zero
  assert_lo_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_q |-> (rdata[LOW_BITS-1:1] == '0));

  // R5: reserved bits of the high half read as zero
  assert_hi_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi_q |-> (rdata[DW-1:TOP_USED] == '0));

endmodule

// File: rtl/cfgwin_match.sv
module cfgwin_match
  import cfgwin_pkg::*;
#(
  parameter int AW_REQ    = REQ_AW,
  parameter int BASE_BITS = BASE_W,
  parameter int LOW_BITS  = WIN_LOG2
) (
  input  logic                 req_valid,
  input  logic [AW_REQ-1:0]    req_addr,
  input  logic [BASE_BITS-1:0] base,
  input  logic                 enable,
  output logic                 hit,
  output logic [LOW_BITS-1:0]  ofs
);
  logic page_eq, out_of_range;

  assign page_eq      = (page_of(req_addr) == base);
  assign out_of_range = beyond_phys(req_addr);
  assign hit = req_valid && enable && page_eq && !out_of_range;
  assign ofs = hit ? offset_of(req_addr) : '0;
endmodule

// File: rtl/cfgwin_allow.sv
module cfgwin_allow
  import cfgwin_pkg::*;
#(
  parameter int LOW_BITS = WIN_LOG2,
  parameter int NSPAN    = N_SPANS
) (
  input  logic [LOW_BITS-1:0] ofs,
  output logic                in_list
);
  logic [NSPAN-1:0] span_hit;

  for (genvar s = 0; s < NSPAN; s++) begin : g_span
    assign span_hit[s] = inside_span(ofs, OPEN_SPANS[s]);
  end

  assign in_list = |span_hit;
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter int AW_REQ    = REQ_AW,
  parameter int ADDR_PHYS = PHYS_AW,
  parameter int LOW_BITS  = WIN_LOG2,
  parameter int DW        = CFG_DW,
  parameter int AW        = CFG_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr_en,
  input  logic                cfg_rd_en,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [DW-1:0]       cfg_wdata,
  input  logic [DW/8-1:0]     cfg_be,
  output logic [DW-1:0]       cfg_rdata,
  input  logic                lock_trusted,
  input  logic                lock_mgmt,
  input  logic                req_valid,
  input  logic [AW_REQ-1:0]   req_addr,
  output logic                win_claim,
  output logic                win_permit,
  output logic [LOW_BITS-1:0] win_offset
);
  localparam int BASE_BITS = ADDR_PHYS - LOW_BITS;

  logic                 lock_any;
  logic [BASE_BITS-1:0] base;
  logic                 enable;
  logic                 hit;
  logic [LOW_BITS-1:0]  ofs;
  logic                 allow_hit;

  assign lock_any = lock_trusted || lock_mgmt;

  cfgwin_regs #(
    .BASE_BITS(BASE_BITS), .LOW_BITS(LOW_BITS), .DW(DW), .AW(AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .rd_en(cfg_rd_en),
    .addr(cfg_addr), .wdata(cfg_wdata), .be(cfg_be), .lock_any(lock_any),
    .rdata(cfg_rdata), .base(base), .enable(enable)
  );

  cfgwin_match #(
    .AW_REQ(AW_REQ), .BASE_BITS(BASE_BITS), .LOW_BITS(LOW_BITS)
  ) u_match (
    .req_valid(req_valid), .req_addr(req_addr), .base(base),
    .enable(enable), .hit(hit), .ofs(ofs)
  );

  cfgwin_allow #(.LOW_BITS(LOW_BITS)) u_allow (
    .ofs(ofs), .in_list(allow_hit)
  );

  assign win_claim  = hit;
  assign win_offset = ofs;
  assign win_permit = hit && (!lock_any || allow_hit);

  // R11: permission only ever accompanies a claim
  assert_permit_needs_claim_R11: assert property (@(posedge clk) disable iff (!rst_n)
    win_permit |-> win_claim);

  // R1: a claim requires the stored enable bit
  assert_claim_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_claim |-> enable);

  // R9: under lock, a claim outside every open span is refused
  assert_locked_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_claim && lock_any && !allow_hit) |-> !win_permit);

  // R8: with no lock, every claim is permitted
  assert_unlocked_permit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_claim && !lock_any) |-> win_permit);

endmodule

// File: tb/cfgwin_decoder_tb.sv
`timescale 1ns/1ps
module cfgwin_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_rdata;
  logic        lock_trusted = 1'b0, lock_mgmt = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        win_claim, win_permit;
  logic [13:0] win_offset;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfgwin_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
    .cfg_rdata(cfg_rdata), .lock_trusted(lock_trusted), .lock_mgmt(lock_mgmt),
    .req_valid(req_valid), .req_addr(req_addr), .win_claim(win_claim),
    .win_permit(win_permit), .win_offset(win_offset)
  );

  // {lock_trusted, lock_mgmt, addr[63:0], exp_claim, exp_permit}; base 0xA_BCDE_4000
  localparam int NV = 24;
  localparam logic [67:0] VEC [NV] = '{
    {2'b10, 64'h0000_000A_BCDE_42B7, 2'b10},
    {2'b10, 64'h0000_000A_BCDE_42B8, 2'b11},
    {2'b10, 64'h0000_000A_BCDE_42BF, 2'b11},
    {2'b10, 64'h0000_000A_BCDE_42C0, 2'b10},
    {2'b10, 64'h0000_000A_BCDE_46B7, 2'b10},
    {2'b10, 64'h0000_000A_BCDE_46B8, 2'b11},
    {2'b10, 64'h0000_000A_BCDE_46BF, 2'b11},
    {2'b10, 64'h0000_000A_BCDE_46C0, 2'b10},
    {2'b10, 64'h0000_000A_BCDE_4CCF, 2'b10},
    {2'b10, 64'h0000_000A_BCDE_4CD0, 2'b11},
    {2'b10, 64'h0000_000A_BCDE_4CFF, 2'b11},
    {2'b10, 64'h0000_000A_BCDE_4D00, 2'b10},
    {2'b10, 64'h0000_000A_BCDE_6FFF, 2'b10},
    {2'b10, 64'h0000_000A_BCDE_7000, 2'b11},
    {2'b10, 64'h0000_000A_BCDE_7FFF, 2'b11},
    {2'b10, 64'h0000_000A_BCDE_4000, 2'b10},
    {2'b00, 64'h0000_000A_BCDE_4000, 2'b11},
    {2'b00, 64'h0000_000A_BCDE_7FFF, 2'b11},
    {2'b01, 64'h0000_000A_BCDE_42B8, 2'b11},
    {2'b01, 64'h0000_000A_BCDE_4100, 2'b10},
    {2'b00, 64'h0000_000A_BCDE_8000, 2'b00},
    {2'b00, 64'h0000_000A_BCDE_3FFF, 2'b00},
    {2'b00, 64'h0000_010A_BCDE_4000, 2'b00},
    {2'b01, 64'h8000_000A_BCDE_42B8, 2'b00}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = b;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    check(req, {32'h0, cfg_rdata}, {32'h0, exp});
  endtask

  // Drives one request and compares {claim, permit, offset}
  task automatic req_check(input string req, input logic v, input logic [63:0] a,
                           input logic ec, input logic ep);
    logic [13:0] eo;
    @(negedge clk);
    req_valid = v; req_addr = a;
    #1;
    eo = ec ? a[13:0] : 14'h0;
    check(req, {48'h0, win_claim, win_permit, win_offset}, {48'h0, ec, ep, eo});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R3: reset state
    cfg_read_check("R3 low half after reset", 8'h48, 32'h0);
    cfg_read_check("R3 high half after reset", 8'h4C, 32'h0);
    req_check("R3 no claim after reset", 1'b1, 64'h0, 1'b0, 1'b0);

    // R5: reserved bits ignore writes
    cfg_write(8'h48, 32'hFFFF_FFFF, 4'hF);
    cfg_read_check("R5 low reserved", 8'h48, 32'hFFFF_C001);
    cfg_write(8'h4C, 32'hFFFF_FFFF, 4'hF);
    cfg_read_check("R5 high reserved", 8'h4C, 32'h0000_000F);
    cfg_read_check("R4 unmapped offset", 8'h50, 32'h0);

    // R4: program base 0xA_BCDE_4000 and enable
    cfg_write(8'h48, 32'hBCDE_4001, 4'hF);
    cfg_write(8'h4C, 32'h0000_000A, 4'hF);
    cfg_read_check("R4 low layout", 8'h48, 32'hBCDE_4001);
    cfg_read_check("R4 high layout", 8'h4C, 32'h0000_000A);

    // Vector table: R1 R2 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      lock_trusted = VEC[i][67];
      lock_mgmt    = VEC[i][66];
      req_check($sformatf("R1 R2 R8 R9 R10 R11 vector %0d", i), 1'b1,
                VEC[i][65:2], VEC[i][1], VEC[i][0]);
    end
    lock_trusted = 1'b0; lock_mgmt = 1'b0;

    // R1 / R6: toggle enable through byte lane 0 only
    cfg_write(8'h48, 32'h0000_0000, 4'b0001);
    cfg_read_check("R6 lane0 clears enable only", 8'h48, 32'hBCDE_4000);
    req_check("R1 disabled no claim", 1'b1, 64'h0000_000A_BCDE_4100, 1'b0, 1'b0);
    cfg_write(8'h48, 32'hFFFF_FF01, 4'b0001);
    req_check("R1 re-enabled claim", 1'b1, 64'h0000_000A_BCDE_4100, 1'b1, 1'b1);
    cfg_read_check("R6 lane0 write keeps base", 8'h48, 32'hBCDE_4001);

    // R6: top lane only
    cfg_write(8'h48, 32'h0000_0000, 4'b1000);
    cfg_read_check("R6 lane3 only", 8'h48, 32'h00DE_4001);
    cfg_write(8'h48, 32'hBC00_0000, 4'b1000);
    cfg_read_check("R6 lane3 restore", 8'h48, 32'hBCDE_4001);

    // R7 / R10: trusted lock alone freezes fields
    lock_trusted = 1'b1;
    cfg_write(8'h48, 32'h0000_0000, 4'hF);
    cfg_read_check("R7 R10 trusted lock blocks low write", 8'h48, 32'hBCDE_4001);
    lock_trusted = 1'b0; lock_mgmt = 1'b1;
    cfg_write(8'h4C, 32'h0000_0003, 4'hF);
    cfg_read_check("R7 R10 mgmt lock blocks high write", 8'h4C, 32'h0000_000A);
    req_check("R7 claim uses frozen base", 1'b1, 64'h0000_000A_BCDE_7000, 1'b1, 1'b1);
    lock_mgmt = 1'b0;
    req_check("R7 unlocked after release", 1'b1, 64'h0000_000A_BCDE_4000, 1'b1, 1'b1);

    // R1: no request valid
    req_check("R1 idle request", 1'b0, 64'h0000_000A_BCDE_4000, 1'b0, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule